// File: doc/BRIEF.md
# DMA Channel Register Interface

This block is the host-facing register file of a four-channel DMA controller. A host reaches it through an 8-bit I/O port bus with a 4-bit offset. Each channel owns a 16-bit transfer address and a 16-bit transfer count. Both are reached through byte-wide ports. A single shared byte-pointer flip-flop decides whether an access hits the low or the high half of the register. Around these sit a per-channel mode byte and a per-channel mask bit. There are also bus commands that reset the pointer, perform a master clear, and clear or load all masks at once.

Every written address or count byte lands in both a base copy and a current copy. The transfer engine sees both copies on its outputs. It can overwrite the current copies of one channel per cycle as a transfer proceeds. Software loads a count of N transfers as N-1, so 0x0000 means one transfer and 0xFFFF means 65536. Reads of the count or address ports return the current copy, taking the same pointer flip-flop into account. Arbitration and memory cycles belong to the transfer engine and sit outside this block.

Top module: `dmac_regif`

## Requirements
- R1: While reset is low, all four mask bits read 1, the byte pointer selects the low byte, and every address, count and mode value is zero.
- R2: A write to offset 2n (n = 0..3) writes channel n's address byte. The low byte is written when the pointer is clear and the high byte when it is set, and the byte goes into both the base and the current copy.
- R3: A write to offset 2n+1 loads channel n's count in the same two-byte way, into both the base and the current copy.
- R4: Every read or write at offsets 0x0 to 0x7 toggles the one pointer shared by all channels. So after a low-byte write to one port, the next byte at any other register port goes to that port's high half.
- R5: A write of any value to offset 0xC clears the pointer.
- R6: A read at offset 2n+1 returns channel n's current count, and a read at 2n returns its current address, each as the half chosen by the pointer. Reads at offsets 0x8 to 0xF return 0x00 and leave the pointer unchanged.
- R7: A write to offset 0xA selects a channel with data bits 1:0. Data bit 2 set masks that channel and bit 2 clear unmasks it. Other channels' masks are untouched.
- R8: A write to offset 0xB stores the whole data byte as the mode of the channel in data bits 1:0. For example, 0x44|n selects I/O-to-memory, 0x48|n selects memory-to-I/O and 0xC0|n selects cascade.
- R9: A write to offset 0xD clears the pointer and sets all four mask bits. Addresses, counts and modes keep their values.
- R10: A write to offset 0xE clears all masks. A write to offset 0xF loads mask bit n from data bit n.
- R11: When the engine update strobe is high, the engine's address and count go into the current copies of the engine-selected channel, and the base copies are unchanged. A bus byte write to the same register in the same cycle wins for the half it writes.
- R12: Writes to offsets 0x8 and 0x9 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| eng_we | input | 1 | Engine update strobe for current copies |
| eng_ch | input | 2 | Channel the engine updates |
| eng_cur_addr | input | 16 | New current address |
| eng_cur_cnt | input | 16 | New current count |
| ch_base_addr | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| ch_cur_addr | output | 64 | Current addresses, same packing |
| ch_base_cnt | output | 64 | Base counts, same packing |
| ch_cur_cnt | output | 64 | Current counts, same packing |
| ch_mode | output | 32 | Mode bytes, channel n at bits 8n+7:8n |
| ch_mask | output | 4 | Mask bit per channel, 1 = masked |

## Verification
The block has no parameters, so the bench builds it with its fixed shape: four channels, 16-bit registers and a 4-bit offset space. Because that space is so small, the random stimulus can reach every offset and both pointer phases many times. Engine updates are mixed into the random sequence, some in the same cycle as bus byte writes to the same channel, so both the bus-over-engine priority and the pointer shared across ports come up often. The directed part covers the cross-port pointer case and a master clear issued with the pointer set.

// File: rtl/dmac_regif.sv
module dmac_regif (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic        eng_we,
  input  logic [1:0]  eng_ch,
  input  logic [15:0] eng_cur_addr,
  input  logic [15:0] eng_cur_cnt,
  output logic [63:0] ch_base_addr,
  output logic [63:0] ch_cur_addr,
  output logic [63:0] ch_base_cnt,
  output logic [63:0] ch_cur_cnt,
  output logic [31:0] ch_mode,
  output logic [3:0]  ch_mask
);
  localparam int NCH = 4;

  logic        ptr;
  logic [15:0] base_a [NCH];
  logic [15:0] base_c [NCH];
  logic [15:0] cur_a  [NCH];
  logic [15:0] cur_c  [NCH];
  logic [15:0] nxt_a  [NCH];
  logic [15:0] nxt_c  [NCH];
  logic [7:0]  mode   [NCH];
  logic [3:0]  mask;

  wire       reg_sel = !bus_addr[3];
  wire [1:0] sel_ch  = bus_addr[2:1];
  wire       sel_cnt = bus_addr[0];
  wire       reg_wr  = bus_wr && reg_sel;
  wire       reg_rd  = bus_rd && reg_sel;
  wire       cmd_wr  = bus_wr && bus_addr[3];

  wire [15:0] rd_word = sel_cnt ? cur_c[sel_ch] : cur_a[sel_ch];
  assign bus_rdata = reg_rd ? (ptr ? rd_word[15:8] : rd_word[7:0]) : 8'h00;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      nxt_a[i] = cur_a[i];
      nxt_c[i] = cur_c[i];
      if (eng_we && eng_ch == 2'(i)) begin
        nxt_a[i] = eng_cur_addr;
        nxt_c[i] = eng_cur_cnt;
      end
      if (reg_wr && sel_ch == 2'(i)) begin
        if (sel_cnt) begin
          if (ptr) nxt_c[i][15:8] = bus_wdata;
          else     nxt_c[i][7:0]  = bus_wdata;
        end else begin
          if (ptr) nxt_a[i][15:8] = bus_wdata;
          else     nxt_a[i][7:0]  = bus_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= 1'b0;
      mask <= 4'hF;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
        mode[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        cur_a[i] <= nxt_a[i];
        cur_c[i] <= nxt_c[i];
        if (reg_wr && sel_ch == 2'(i)) begin
          if (sel_cnt) begin
            if (ptr) base_c[i][15:8] <= bus_wdata;
            else     base_c[i][7:0]  <= bus_wdata;
          end else begin
            if (ptr) base_a[i][15:8] <= bus_wdata;
            else     base_a[i][7:0]  <= bus_wdata;
          end
        end
      end
      if (reg_wr || reg_rd) ptr <= !ptr;
      if (cmd_wr) begin
        case (bus_addr[2:0])
          3'd2: mask[bus_wdata[1:0]] <= bus_wdata[2];
          3'd3: mode[bus_wdata[1:0]] <= bus_wdata;
          3'd4: ptr <= 1'b0;
          3'd5: begin ptr <= 1'b0; mask <= 4'hF; end
          3'd6: mask <= 4'h0;
          3'd7: mask <= bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_base_addr[g*16 +: 16] = base_a[g];
    assign ch_cur_addr[g*16 +: 16]  = cur_a[g];
    assign ch_base_cnt[g*16 +: 16]  = base_c[g];
    assign ch_cur_cnt[g*16 +: 16]   = cur_c[g];
    assign ch_mode[g*8 +: 8]        = mode[g];
  end
  assign ch_mask = mask;
endmodule

module dmac_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        ptr,
  input logic [3:0]  ch_mask,
  input logic [63:0] ch_base_addr,
  input logic [63:0] ch_base_cnt
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ch_mask == 4'hF && !ptr));

  a_r4_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_addr[3]) |=> ptr != $past(ptr));

  a_r5_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hC) |=> !ptr);

  a_r7_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hA) |=> ch_mask[$past(bus_wdata[1:0])] == $past(bus_wdata[2]));

  a_r9_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hD) |=> (ch_mask == 4'hF && !ptr));

  a_r10_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hE) |=> ch_mask == 4'h0);

  a_r10_load_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hF) |=> ch_mask == $past(bus_wdata[3:0]));

  a_r11_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_addr[3]) |=> ($stable(ch_base_addr) && $stable(ch_base_cnt)));
endmodule

bind dmac_regif dmac_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .ptr(ptr), .ch_mask(ch_mask),
  .ch_base_addr(ch_base_addr), .ch_base_cnt(ch_base_cnt)
);

// File: tb/tb_dmac_regif.sv
module tb_dmac_regif;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        eng_we = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic [15:0] eng_cur_addr = '0, eng_cur_cnt = '0;
  logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;
  logic [31:0] ch_mode;
  logic [3:0]  ch_mask;

  dmac_regif dut (.*);

  int checks = 0, fails = 0;
  logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
  logic [7:0]  m_mode [4];
  logic [3:0]  m_mask;
  logic        m_ptr;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pk(input logic [15:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  task automatic check_all(string req);
    chk({req, " base_addr"}, ch_base_addr, pk(m_ba[0], m_ba[1], m_ba[2], m_ba[3]));
    chk({req, " cur_addr"},  ch_cur_addr,  pk(m_ca[0], m_ca[1], m_ca[2], m_ca[3]));
    chk({req, " base_cnt"},  ch_base_cnt,  pk(m_bc[0], m_bc[1], m_bc[2], m_bc[3]));
    chk({req, " cur_cnt"},   ch_cur_cnt,   pk(m_cc[0], m_cc[1], m_cc[2], m_cc[3]));
    chk({req, " mode"}, 64'(ch_mode), 64'({m_mode[3], m_mode[2], m_mode[1], m_mode[0]}));
    chk({req, " mask"}, 64'(ch_mask), 64'(m_mask));
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [15:0] w;
    if (a[3]) return 8'h00;
    w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
    return m_ptr ? w[15:8] : w[7:0];
  endfunction

  function automatic string tag(input bit w, input bit e, input logic [3:0] a);
    if (!w) return e ? "R11" : "R6";
    if (e && !a[3]) return "R11";
    case (a)
      4'hA: return "R7";
      4'hB: return "R8";
      4'hC: return "R5";
      4'hD: return "R9";
      4'hE, 4'hF: return "R10";
      4'h8, 4'h9: return "R12";
      default: return a[0] ? "R3" : "R2";
    endcase
  endfunction

  task automatic model(bit w, bit r, logic [3:0] a, logic [7:0] d,
                       bit e, logic [1:0] ec, logic [15:0] ea, logic [15:0] en);
    if (e) begin m_ca[ec] = ea; m_cc[ec] = en; end
    if (w) begin
      if (!a[3]) begin
        if (a[0]) begin
          if (m_ptr) begin m_bc[a[2:1]][15:8] = d; m_cc[a[2:1]][15:8] = d; end
          else       begin m_bc[a[2:1]][7:0]  = d; m_cc[a[2:1]][7:0]  = d; end
        end else begin
          if (m_ptr) begin m_ba[a[2:1]][15:8] = d; m_ca[a[2:1]][15:8] = d; end
          else       begin m_ba[a[2:1]][7:0]  = d; m_ca[a[2:1]][7:0]  = d; end
        end
        m_ptr = !m_ptr;
      end else begin
        case (a)
          4'hA: m_mask[d[1:0]] = d[2];
          4'hB: m_mode[d[1:0]] = d;
          4'hC: m_ptr = 1'b0;
          4'hD: begin m_ptr = 1'b0; m_mask = 4'hF; end
          4'hE: m_mask = 4'h0;
          4'hF: m_mask = d[3:0];
          default: ;
        endcase
      end
    end else if (r && !a[3]) m_ptr = !m_ptr;
  endtask

  task automatic op(bit w, bit r, logic [3:0] a, logic [7:0] d,
                    bit e = 0, logic [1:0] ec = 0, logic [15:0] ea = 0, logic [15:0] en = 0);
    string t;
    t = tag(w, e, a);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    eng_we = e; eng_ch = ec; eng_cur_addr = ea; eng_cur_cnt = en;
    #1;
    if (r && !w) chk("R6 rdata", 64'(bus_rdata), 64'(exp_rd(a)));
    @(posedge clk);
    model(w, r, a, d, e, ec, ea, en);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_we = 0;
    check_all(t);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
    end
    m_mask = 4'hF; m_ptr = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    // R1: pointer starts low, read of count port gives low byte of zero
    op(0, 1, 4'h1, 0);
    op(1, 0, 4'hC, 8'h5A);               // R5
    op(1, 0, 4'h0, 8'h34);               // R2 low
    op(1, 0, 4'h0, 8'h12);               // R2 high
    op(1, 0, 4'h3, 8'hFF);               // R3 count 256 -> 0x00FF
    op(1, 0, 4'h3, 8'h00);
    op(0, 1, 4'h3, 0);                   // R6 low
    op(0, 1, 4'h3, 0);                   // R6 high
    op(0, 1, 4'h9, 0);                   // R6 unused read
    op(1, 0, 4'h4, 8'hAA);               // R4 low of ch2 addr
    op(1, 0, 4'h5, 8'hBB);               // R4 goes to ch2 count high
    chk("R4 shared pointer", 64'(ch_base_cnt[47:32]), 64'(16'hBB00));
    op(1, 0, 4'h6, 8'h11);               // pointer now set
    op(1, 0, 4'hD, 8'h00);               // R9
    op(1, 0, 4'h6, 8'h22);               // R9 low byte after clear
    op(1, 0, 4'hB, 8'h44);               // R8
    op(1, 0, 4'hB, 8'h49);
    op(1, 0, 4'hB, 8'hC2);
    op(1, 0, 4'hE, 8'h00);               // R10
    op(1, 0, 4'hA, 8'h06);               // R7 mask ch2
    op(1, 0, 4'hA, 8'h02);               // R7 unmask ch2
    op(1, 0, 4'hF, 8'hF5);               // R10 load
    op(1, 0, 4'h8, 8'hFF);               // R12
    op(1, 0, 4'h9, 8'hFF);               // R12
    op(0, 0, 4'h0, 0, 1, 2'd1, 16'hBEEF, 16'h0042);   // R11
    op(1, 0, 4'h2, 8'h77, 1, 2'd1, 16'h1111, 16'h2222); // R11 priority
    void'($urandom(32'd2024));
    for (int k = 0; k < 800; k++) begin
      int kind;
      kind = int'($urandom % 8);
      if (kind < 4)
        op(1, 0, 4'($urandom), 8'($urandom));
      else if (kind < 6)
        op(0, 1, 4'($urandom), 0);
      else if (kind == 6)
        op(0, 0, 4'h0, 0, 1, 2'($urandom), 16'($urandom), 16'($urandom));
      else
        op(1, 0, {1'b0, 3'($urandom)}, 8'($urandom), 1, 2'($urandom),
           16'($urandom), 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule